// File: doc/BRIEF.md
# Floating-Point Half-Immediate Load Unit

This execution unit builds floating-point register values from 16-bit immediates without touching memory. It performs two operations. The load operation places the immediate in the upper half of a single-format word, as a bfloat16 value, and widens that word to double format. The insert operation narrows a 64-bit register operand to single format, overwrites the low half of that single word with the immediate, and widens the result back to double format. Issuing a load and then an insert on the same register builds any 32-bit single-format bit pattern from two 32-bit instructions.

Neither conversion rounds, raises an exception or reports a flag. Widening cannot be bypassed: single-format denormals are normalised into ordinary double-format numbers. Narrowing copies bits for values that fit in single format, shifts values in the single denormal range, and copies bits with no range check for values below that range.

Requests arrive on a valid/ready handshake. The result is registered one cycle after a request is accepted. The output register is controlled by a two-state machine with the states ST_EMPTY and ST_FULL. Its transitions are:
- FILL: ST_EMPTY to ST_FULL when a request is accepted.
- DRAIN: ST_FULL to ST_EMPTY when the result is taken and no request arrives.
- REFILL: ST_FULL to ST_FULL when the result is taken and a request is accepted in the same cycle.
- STALL: ST_FULL to ST_FULL when the consumer is not ready.
- IDLE: ST_EMPTY to ST_EMPTY when no request arrives.

Top module: `fphimm_unit`

## Requirements
- R1: With `in_op` = 0 (load), the result is the widening of the single word {in_imm, 16'h0000}, so bit 15 of the immediate becomes the result sign.
- R2: Widening a single value whose exponent is 1..254 gives exponent + 896 in result bits 62:52 and the 23-bit fraction in bits 51:29. Result bits 28:0 are always zero.
- R3: Widening keeps the sign of a zero. Single exponent 255 (infinity or NaN) gives double exponent 2047 with the fraction in bits 51:29.
- R4: Widening a single denormal with leading fraction one at bit p gives double exponent 874 + p and the bits below that one in the upper fraction positions. No result has a zero exponent with a non-zero fraction.
- R5: With `in_op` = 1 (insert), the result is the widening of {narrow(in_src)[31:16], in_imm}. The result sign equals bit 63 of `in_src`.
- R6: Narrowing an operand whose exponent field (bits 62:52) is 0 or above 896 returns {src[63], src[62], src[58:29]}.
- R7: Narrowing an operand with exponent e in 874..896 returns sign src[63], exponent 0 and fraction ({1, src[51:0]} >> (897 - e))[51:29].
- R8: Narrowing an operand with exponent 1..873 uses the same bit selection as R6, with no range check.
- R9: A load of hi followed by an insert of lo on that result yields the widening of {hi, lo}, for any 32-bit pattern.
- R10: `in_ready` is high when the output register is empty or is being read in the same cycle. An accepted request appears on `out_data` with `out_valid` one cycle later, and a request can be accepted every cycle.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady.
- R12: During and directly after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_op | input | 1 | 0 = load immediate, 1 = insert immediate |
| in_imm | input | 16 | Immediate half-word |
| in_src | input | 64 | Double-format source operand (used by insert) |
| out_valid | output | 1 | Registered result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Double-format result |

## Verification
Two things can happen in the same clock edge: the held result is drained and a new request is accepted (the REFILL transition). The bench provokes this by streaming 65536 load requests and thousands of insert requests with `out_ready` held high, so every edge both consumes and refills the register. Each result is compared against a bench model at the next falling edge, so a lost or duplicated result would show up as a mismatch. A directed stall then holds a result under back-pressure and releases it while a new request waits, and checks that the held value stays put and the waiting request follows one cycle after release.

// File: rtl/fphimm_pkg.sv
package fphimm_pkg;

    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int IMM_W      = 16;

    localparam int SGL_W      = 1 + SGL_EXP_W + SGL_FRAC_W;
    localparam int DBL_W      = 1 + DBL_EXP_W + DBL_FRAC_W;
    localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
    localparam int BIAS_DIFF  = DBL_BIAS - SGL_BIAS;
    localparam int FRAC_SHIFT = DBL_FRAC_W - SGL_FRAC_W;
    localparam int DEN_LO     = BIAS_DIFF - SGL_FRAC_W + 1;
    localparam int LZ_W       = $clog2(SGL_FRAC_W);

    typedef enum logic {
        OP_LOAD   = 1'b0,
        OP_INSERT = 1'b1
    } op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } state_e;

endpackage

// File: rtl/fphimm_widen.sv
module fphimm_widen
    import fphimm_pkg::*;
(
    input  logic [SGL_W-1:0] sgl_i,
    output logic [DBL_W-1:0] dbl_o
);

    logic                  sgn;
    logic [SGL_EXP_W-1:0]  exp_s;
    logic [SGL_FRAC_W-1:0] frac_s;
    logic [LZ_W-1:0]       lz;
    logic [SGL_FRAC_W:0]   shl;
    logic [SGL_FRAC_W-1:0] norm_frac;
    logic [DBL_EXP_W-1:0]  den_exp;
    logic [DBL_EXP_W-1:0]  nrm_exp;

    assign sgn    = sgl_i[SGL_W-1];
    assign exp_s  = sgl_i[SGL_FRAC_W +: SGL_EXP_W];
    assign frac_s = sgl_i[SGL_FRAC_W-1:0];

    // Priority encoder: count of zeros above the leading fraction one.
    always_comb begin
        lz = '0;
        for (int i = 0; i < SGL_FRAC_W; i++) begin
            if (frac_s[i]) lz = LZ_W'(SGL_FRAC_W - 1 - i);
        end
    end

    assign shl       = {frac_s, 1'b0} << lz;
    assign norm_frac = shl[SGL_FRAC_W-1:0];
    assign den_exp   = DBL_EXP_W'(BIAS_DIFF) - DBL_EXP_W'(lz);
    assign nrm_exp   = DBL_EXP_W'(exp_s) + DBL_EXP_W'(BIAS_DIFF);

    always_comb begin
        if (exp_s == '0 && frac_s == '0) begin
            dbl_o = {sgn, {(DBL_W-1){1'b0}}};
        end else if (exp_s == '0) begin
            dbl_o = {sgn, den_exp, norm_frac, {FRAC_SHIFT{1'b0}}};
        end else if (exp_s == '1) begin
            dbl_o = {sgn, {DBL_EXP_W{1'b1}}, frac_s, {FRAC_SHIFT{1'b0}}};
        end else begin
            dbl_o = {sgn, nrm_exp, frac_s, {FRAC_SHIFT{1'b0}}};
        end
    end

endmodule

// File: rtl/fphimm_narrow.sv
module fphimm_narrow
    import fphimm_pkg::*;
(
    input  logic [DBL_W-1:0] dbl_i,
    output logic [SGL_W-1:0] sgl_o
);

    logic [DBL_EXP_W-1:0]  exp_d;
    logic [DBL_FRAC_W:0]   mant;
    logic [DBL_EXP_W-1:0]  sh;
    logic [DBL_FRAC_W:0]   mant_sh;
    logic [SGL_W-1:0]      pick;
    logic [SGL_W-1:0]      den;
    logic                  in_den;

    assign exp_d   = dbl_i[DBL_FRAC_W +: DBL_EXP_W];
    assign mant    = {1'b1, dbl_i[DBL_FRAC_W-1:0]};
    assign sh      = DBL_EXP_W'(BIAS_DIFF + 1) - exp_d;
    assign mant_sh = mant >> sh;

    // Plain bit selection: sign, exponent MSB, then low 30 bits of the field.
    assign pick = {dbl_i[DBL_W-1], dbl_i[DBL_W-2], dbl_i[FRAC_SHIFT +: SGL_W-2]};
    assign den  = {dbl_i[DBL_W-1], {SGL_EXP_W{1'b0}},
                   mant_sh[DBL_FRAC_W-1 -: SGL_FRAC_W]};

    assign in_den = (exp_d >= DBL_EXP_W'(DEN_LO)) && (exp_d <= DBL_EXP_W'(BIAS_DIFF));

    always_comb begin
        if (in_den) sgl_o = den;
        else        sgl_o = pick;
    end

endmodule

// File: rtl/fphimm_ctrl.sv
module fphimm_ctrl
    import fphimm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic accept,
    output logic out_valid
);

    state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid) state_d = ST_FULL;      // FILL
                else          state_d = ST_EMPTY;     // IDLE
            end
            ST_FULL: begin
                if (out_ready && !in_valid) state_d = ST_EMPTY; // DRAIN
                else                        state_d = ST_FULL;  // REFILL / STALL
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
        accept = in_valid && in_ready;
    end

endmodule

// File: rtl/fphimm_datapath.sv
module fphimm_datapath
    import fphimm_pkg::*;
(
    input  logic             op_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [DBL_W-1:0] src_i,
    output logic [DBL_W-1:0] res_o
);

    logic [SGL_W-1:0] narrowed;
    logic [SGL_W-1:0] merged;

    fphimm_narrow u_narrow (
        .dbl_i (src_i),
        .sgl_o (narrowed)
    );

    always_comb begin
        if (op_e'(op_i) == OP_INSERT)
            merged = {narrowed[SGL_W-1:IMM_W], imm_i};
        else
            merged = {imm_i, {(SGL_W-IMM_W){1'b0}}};
    end

    fphimm_widen u_widen (
        .sgl_i (merged),
        .dbl_o (res_o)
    );

endmodule

// File: rtl/fphimm_unit.sv
module fphimm_unit
    import fphimm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_op,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [DBL_W-1:0] in_src,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DBL_W-1:0] out_data
);

    logic             accept;
    logic [DBL_W-1:0] res_d;
    logic [DBL_W-1:0] res_q;

    fphimm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .accept    (accept),
        .out_valid (out_valid)
    );

    fphimm_datapath u_dp (
        .op_i  (in_op),
        .imm_i (in_imm),
        .src_i (in_src),
        .res_o (res_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      res_q <= '0;
        else if (accept) res_q <= res_d;
    end

    assign out_data = res_q;

endmodule

// File: rtl/fphimm_chk.sv
module fphimm_chk
    import fphimm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_op,
    input logic [IMM_W-1:0] in_imm,
    input logic [DBL_W-1:0] in_src,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DBL_W-1:0] out_data
);

    AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !out_valid); // R12

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R10

    AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R10

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11

    AST_LOAD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == OP_LOAD) |=> out_data[DBL_W-1] == $past(in_imm[IMM_W-1])); // R1

    AST_INSERT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == OP_INSERT) |=> out_data[DBL_W-1] == $past(in_src[DBL_W-1])); // R5

    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data[FRAC_SHIFT-1:0] == '0); // R2

    AST_NO_DENORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data[DBL_FRAC_W +: DBL_EXP_W] == '0) |-> out_data[DBL_FRAC_W-1:0] == '0); // R4

endmodule

bind fphimm_unit fphimm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_imm    (in_imm),
    .in_src    (in_src),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/fphimm_unit_tb.sv
module fphimm_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_op = 1'b0;
    logic [15:0] in_imm = '0;
    logic [63:0] in_src = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;

    int errors = 0;
    int checks = 0;

    logic        have_prev = 1'b0;
    logic [63:0] prev_exp = '0;
    string       prev_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    fphimm_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_op     (in_op),
        .in_imm    (in_imm),
        .in_src    (in_src),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    function automatic logic [63:0] ref_widen(input logic [31:0] s);
        logic [7:0]  e;
        logic [22:0] f;
        logic [23:0] m;
        int          ex;
        e = s[30:23];
        f = s[22:0];
        if (e == 8'd0 && f == 23'd0) return {s[31], 63'd0};
        if (e == 8'hFF) return {s[31], 11'h7FF, f, 29'd0};
        if (e != 8'd0) return {s[31], 11'(int'(e) - 127 + 1023), f, 29'd0};
        m  = {1'b0, f};
        ex = -126;
        while (!m[23]) begin
            m  = m << 1;
            ex = ex - 1;
        end
        return {s[31], 11'(ex + 1023), m[22:0], 29'd0};
    endfunction

    function automatic logic [31:0] ref_narrow(input logic [63:0] d);
        int          e;
        int          ex;
        logic [52:0] fr;
        e = int'(d[62:52]);
        if (e > 896 || e == 0 || e < 874) return {d[63:62], d[58:29]};
        ex = e - 1023;
        fr = {1'b1, d[51:0]};
        while (ex < -126) begin
            fr = fr >> 1;
            ex = ex + 1;
        end
        return {d[63], 8'd0, fr[51:29]};
    endfunction

    function automatic string widen_tag(input logic [31:0] s);
        if (s[30:23] == 8'd0 && s[22:0] != 23'd0) return "R4";
        if (s[30:23] == 8'd0 || s[30:23] == 8'hFF) return "R3";
        return "R2";
    endfunction

    function automatic string narrow_tag(input logic [63:0] d);
        int e;
        e = int'(d[62:52]);
        if (e >= 874 && e <= 896) return "R7";
        if (e >= 1 && e <= 873) return "R8";
        return "R6";
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Streamed request: check the previous result, then drive this one.
    task automatic push(input logic op, input logic [15:0] imm, input logic [63:0] src,
                        input logic [63:0] exp, input string tag);
        @(negedge clk);
        if (have_prev) begin
            check1("R10", out_valid, 1'b1);
            check64(prev_tag, out_data, prev_exp);
        end
        check1("R10", in_ready, 1'b1);
        in_valid  = 1'b1;
        in_op     = op;
        in_imm    = imm;
        in_src    = src;
        prev_exp  = exp;
        prev_tag  = tag;
        have_prev = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (have_prev) begin
            check1("R10", out_valid, 1'b1);
            check64(prev_tag, out_data, prev_exp);
        end
        in_valid  = 1'b0;
        have_prev = 1'b0;
    endtask

    task automatic insert_case(input logic [63:0] src, input logic [15:0] imm);
        logic [31:0] n;
        n = ref_narrow(src);
        push(1'b1, imm, src, ref_widen({n[31:16], imm}), narrow_tag(src));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] corners [12];
        logic [63:0] got;
        logic [31:0] pat;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        check1("R12", out_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R12", out_valid, 1'b0);
        check1("R12", in_ready, 1'b1);

        // R1 with R2/R3/R4: every immediate in load mode, back to back.
        for (int i = 0; i < 65536; i++) begin
            push(1'b0, 16'(i), $urandom() | 64'd0, ref_widen({16'(i), 16'd0}),
                 widen_tag({16'(i), 16'd0}));
        end
        flush();

        // R5 with R6/R7/R8: directed corner inputs in insert mode.
        corners[0]  = 64'h0000_0000_0000_0000;
        corners[1]  = 64'h8000_0000_0000_0000;
        corners[2]  = 64'h7FF0_0000_0000_0000;
        corners[3]  = 64'hFFF8_0000_0000_0001;
        corners[4]  = {1'b0, 11'd896, 52'hF_FFFF_FFFF_FFFF};
        corners[5]  = {1'b1, 11'd874, 52'h8_0000_0000_0000};
        corners[6]  = {1'b0, 11'd885, 52'h1_2345_6789_ABCD};
        corners[7]  = {1'b0, 11'd873, 52'hA_AAAA_AAAA_AAAA};
        corners[8]  = 64'h0080_0000_0000_0001;
        corners[9]  = {1'b0, 11'd897, 52'd0};
        corners[10] = 64'h0000_0000_0000_0001;
        corners[11] = 64'hC00F_FFFF_E000_0000;
        for (int i = 0; i < 12; i++) begin
            insert_case(corners[i], 16'hABCD);
            insert_case(corners[i], 16'h0000);
        end
        // Random operands, with exponents spread over every narrowing path.
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] s;
            s = {$urandom(), $urandom()};
            if (i % 3 == 1) s[62:52] = 11'(874 + ($urandom() % 23));
            if (i % 3 == 2) s[62:52] = 11'($urandom() % 874);
            insert_case(s, 16'($urandom()));
        end
        flush();

        // R9: load hi then insert lo on the unit's own result.
        for (int i = 0; i < 600; i++) begin
            pat = $urandom();
            if (i % 4 == 0) pat[30:23] = 8'd0;
            if (i % 4 == 1) pat[30:23] = 8'hFF;
            @(negedge clk);
            in_valid = 1'b1; in_op = 1'b0; in_imm = pat[31:16]; in_src = '0;
            @(negedge clk);
            got = out_data;
            in_op = 1'b1; in_imm = pat[15:0]; in_src = got;
            @(negedge clk);
            in_valid = 1'b0;
            check64("R9", out_data, ref_widen(pat));
        end

        // R10/R11: stall under back-pressure, then refill on release.
        @(negedge clk);
        in_valid = 1'b1; in_op = 1'b0; in_imm = 16'h3F80; out_ready = 1'b1;
        @(negedge clk);
        check64("R1", out_data, 64'h3FF0_0000_0000_0000);
        out_ready = 1'b0; in_imm = 16'hC120;
        #1;
        check1("R10", in_ready, 1'b0);
        @(negedge clk);
        check1("R11", out_valid, 1'b1);
        check64("R11", out_data, 64'h3FF0_0000_0000_0000);
        @(negedge clk);
        check64("R11", out_data, 64'h3FF0_0000_0000_0000);
        out_ready = 1'b1;
        #1;
        check1("R10", in_ready, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        check64("R10", out_data, ref_widen(32'hC120_0000));
        @(negedge clk);
        check1("R10", out_valid, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule